// File: doc/BRIEF.md
# Serial TDM Time Slot Interchanger

This block is a non-blocking time slot switch for eight serial input streams and eight serial output streams. Each stream is framed into 32 eight-bit channels, so a frame holds 256 switchable channels. Incoming bits are gathered into bytes and stored in a data memory at addresses set by the frame position. A connection memory, indexed by output slot, names the source stream and channel for every output slot. It also holds three flags for that slot: an output enable, a delay mode and a control-stream bit.

A frame pulse restarts the internal frame counter. Each serial bit lasts two clock cycles. The data memory has two banks, chosen by the parity of the frame. A slot in constant-delay mode always reads the bank that was filled in the previous frame. A group of channels taken from one input frame therefore leaves together, in its original order, in the next output frame. A slot in minimum-delay mode reads the current frame when its source channel has already been received, and otherwise reads the previous frame.

A separate control output carries one bit per slot, 256 bits per frame. A global drive-enable input can force every serial output into high impedance. Each serial output is given as a data bit and an enable bit; the pad logic outside the block turns the pair into a three-state signal.

Top module: `tsi_switch`

## Requirements
- R1: Synchronous reset (`rst` high) clears the frame counter, the frame parity and the connection memory. After reset, `ser_oe` is all zero and `ser_out` and `ctl_out` are 0.
- R2: When `fsync` is high in a cycle, the next cycle is frame position 0. The position then counts up by one each cycle and wraps from 511 to 0. Input bit period j (0..255) covers positions 2j and 2j+1. Period j carries bit 7-(j mod 8), MSB first, of channel j/8, and is sampled at the end of position 2j+1.
- R3: Output bit period j of each serial output is driven during positions 2j+1 and 2j+2. It carries bit 7-(j mod 8) of the byte selected for output channel j/8.
- R4: For a minimum-delay slot (flag clear) on output channel k, the output carries the source byte received in the same frame when the source channel is less than k. When the source channel is k or greater, it carries the byte received in the previous frame.
- R5: For a constant-delay slot (flag set), the output always carries the source byte from the previous frame, whatever the source channel. A group of such slots keeps its frame and its order.
- R6: `ser_oe[s]` is high through an output channel's bit periods only when that slot's enable flag is set and `drive_en` is high. It changes only at channel boundaries.
- R7: While `drive_en` is low, `ser_oe` is all zero in the same cycle.
- R8: Control bit period j (0..255) on `ctl_out` is driven during positions 2j+1 and 2j+2. It carries the control-stream flag of connection entry j.
- R9: A write with `cfg_we` high stores `cfg_wdata` at entry `cfg_addr`. The entry address is output stream × 32 + output channel. The data fields are: [4:0] source channel, [7:5] source stream, [8] output enable, [9] delay mode (1 = constant), [10] control-stream bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Shift clock, two cycles per serial bit |
| rst | input | 1 | Synchronous active-high reset |
| fsync | input | 1 | Frame pulse; the next cycle is frame position 0 |
| ser_in | input | 8 | Serial input streams, one bit per stream |
| drive_en | input | 1 | Global output drive enable |
| cfg_we | input | 1 | Connection memory write strobe |
| cfg_addr | input | 8 | Connection entry address |
| cfg_wdata | input | 11 | Connection entry contents |
| ser_out | output | 8 | Serial output data, one bit per stream |
| ser_oe | output | 8 | Serial output drive enable per stream |
| ctl_out | output | 1 | Control-stream output |

## Verification
Random channel data are switched through four kinds of map. An identity map, where each source channel equals its output channel, shows that the same-channel case takes the previous frame. Random minimum-delay maps separate same-frame sources from previous-frame sources. A constant-delay map includes one stream that carries a rotated group of channels across the frame boundary, and shows that the whole group comes from one frame in order. A mixed map with random enables and delay modes, run once with the global drive enable high and once with it low, separates the per-slot enable from the global one. The control stream is compared bit by bit in every frame.

// File: rtl/tsi_pkg.sv
package tsi_pkg;
   typedef enum logic {DLY_MIN = 1'b0, DLY_CONST = 1'b1} dly_mode_e;

   // bank select for a data memory read: previous frame unless a
   // minimum-delay slot's source byte is already complete this frame
   function automatic logic pick_bank(dly_mode_e mode, logic src_done, logic cur_bank);
      return (mode == DLY_CONST || !src_done) ? ~cur_bank : cur_bank;
   endfunction
endpackage

// File: rtl/tsi_rx.sv
module tsi_rx #(
   parameter int NSTR = 8,
   parameter int NCH  = 32,
   parameter int W    = 8,
   localparam int CW  = $clog2(NCH),
   localparam int BW  = $clog2(W),
   localparam int PW  = CW + BW + 1
) (
   input  logic                     clk,
   input  logic                     rst,
   input  logic                     fsync,
   input  logic [NSTR-1:0]          ser_in,
   output logic [PW-1:0]            cnt,
   output logic                     fpar,
   output logic                     wr_en,
   output logic [CW-1:0]            wr_chan,
   output logic [NSTR-1:0][W-1:0]   wr_data
);
   logic [NSTR-1:0][W-2:0] sh;

   always_ff @(posedge clk) begin
      if (rst) begin
         cnt  <= '0;
         fpar <= 1'b0;
      end else begin
         cnt  <= fsync ? '0 : cnt + 1'b1;
         fpar <= fpar ^ fsync;
      end
   end

   for (genvar s = 0; s < NSTR; s++) begin : g_deser
      always_ff @(posedge clk) begin
         if (rst)
            sh[s] <= '0;
         else if (cnt[0])
            sh[s] <= {sh[s][W-3:0], ser_in[s]};
      end
      assign wr_data[s] = {sh[s], ser_in[s]};
   end

   assign wr_en   = &cnt[BW:0];
   assign wr_chan = cnt[PW-1:BW+1];

   AST_PHASE_TOGGLE: assert property (@(posedge clk) disable iff (rst)
      !fsync |=> cnt[0] != $past(cnt[0])); // R2
endmodule

// File: rtl/tsi_dmem.sv
module tsi_dmem #(
   parameter int NSTR = 8,
   parameter int NCH  = 32,
   parameter int W    = 8,
   localparam int SW  = $clog2(NSTR),
   localparam int CW  = $clog2(NCH),
   localparam int AW  = SW + CW,
   localparam int NSLOT = NSTR * NCH
) (
   input  logic                     clk,
   input  logic                     wr_en,
   input  logic                     wr_bank,
   input  logic [CW-1:0]            wr_chan,
   input  logic [NSTR-1:0][W-1:0]   wr_data,
   input  logic [NSTR-1:0]          rd_bank,
   input  logic [NSTR-1:0][AW-1:0]  rd_addr,
   output logic [NSTR-1:0][W-1:0]   rd_data
);
   logic [W-1:0] mem [2][NSLOT];

   always_ff @(posedge clk) begin
      if (wr_en)
         for (int s = 0; s < NSTR; s++)
            mem[wr_bank][{SW'(s), wr_chan}] <= wr_data[s];
   end

   for (genvar g = 0; g < NSTR; g++) begin : g_rd
      assign rd_data[g] = mem[rd_bank[g]][rd_addr[g]];
   end
endmodule

// File: rtl/tsi_cmem.sv
module tsi_cmem #(
   parameter int NSTR = 8,
   parameter int NCH  = 32,
   parameter int EW   = 11,
   localparam int AW  = $clog2(NSTR) + $clog2(NCH),
   localparam int NSLOT = NSTR * NCH
) (
   input  logic                      clk,
   input  logic                      rst,
   input  logic                      cfg_we,
   input  logic [AW-1:0]             cfg_addr,
   input  logic [EW-1:0]             cfg_wdata,
   input  logic [NSTR-1:0][AW-1:0]   rt_addr,
   output logic [NSTR-1:0][EW-2:0]   rt_ent,
   input  logic [AW-1:0]             ctl_addr,
   output logic                      ctl_bit
);
   logic [EW-1:0] mem [NSLOT];

   always_ff @(posedge clk) begin
      if (rst) begin
         for (int i = 0; i < NSLOT; i++) mem[i] <= '0;
      end else if (cfg_we) begin
         mem[cfg_addr] <= cfg_wdata;
      end
   end

   for (genvar g = 0; g < NSTR; g++) begin : g_rt
      assign rt_ent[g] = mem[rt_addr[g]][EW-2:0];
   end
   assign ctl_bit = mem[ctl_addr][EW-1];

   AST_CFG_STORE: assert property (@(posedge clk) disable iff (rst)
      cfg_we |=> mem[$past(cfg_addr)] == $past(cfg_wdata)); // R9
endmodule

// File: rtl/tsi_tx.sv
module tsi_tx
   import tsi_pkg::*;
#(
   parameter int NSTR = 8,
   parameter int NCH  = 32,
   parameter int W    = 8,
   localparam int SW  = $clog2(NSTR),
   localparam int CW  = $clog2(NCH),
   localparam int BW  = $clog2(W),
   localparam int PW  = CW + BW + 1,
   localparam int AW  = SW + CW
) (
   input  logic            clk,
   input  logic            rst,
   input  logic [PW-1:0]   cnt,
   input  logic            fpar,
   input  logic [AW+1:0]   ent,
   input  logic [W-1:0]    rd_data,
   output logic            rd_bank,
   output logic [AW-1:0]   rd_addr,
   output logic            ser_bit,
   output logic            oe_q
);
   logic [CW-1:0] cur_ch, src_ch;
   logic          load;
   dly_mode_e     mode;
   logic [W-2:0]  sh;

   assign cur_ch  = cnt[PW-1:BW+1];
   assign src_ch  = ent[CW-1:0];
   assign mode    = dly_mode_e'(ent[AW+1]);
   assign load    = (cnt[BW:0] == '0);
   assign rd_addr = ent[AW-1:0];
   assign rd_bank = pick_bank(mode, src_ch < cur_ch, fpar);

   always_ff @(posedge clk) begin
      if (rst) begin
         sh      <= '0;
         ser_bit <= 1'b0;
         oe_q    <= 1'b0;
      end else if (!cnt[0]) begin
         if (load) begin
            ser_bit <= rd_data[W-1];
            sh      <= rd_data[W-2:0];
            oe_q    <= ent[AW];
         end else begin
            ser_bit <= sh[W-2];
            sh      <= {sh[W-3:0], 1'b0};
         end
      end
   end

   AST_BIT_HOLD: assert property (@(posedge clk) disable iff (rst)
      cnt[0] |=> $stable(ser_bit)); // R3
   AST_OE_SLOT: assert property (@(posedge clk) disable iff (rst)
      (cnt[BW:0] != '0) |=> $stable(oe_q)); // R6
   AST_CONST_BANK: assert property (@(posedge clk) disable iff (rst)
      (load && mode == DLY_CONST) |-> rd_bank != fpar); // R5
   AST_MIN_READY: assert property (@(posedge clk) disable iff (rst)
      (load && rd_bank == fpar) |-> src_ch < cur_ch); // R4
endmodule

// File: rtl/tsi_switch.sv
module tsi_switch #(
   parameter int NSTR = 8,
   parameter int NCH  = 32,
   parameter int W    = 8,
   localparam int SW  = $clog2(NSTR),
   localparam int CW  = $clog2(NCH),
   localparam int BW  = $clog2(W),
   localparam int PW  = CW + BW + 1,
   localparam int AW  = SW + CW,
   localparam int EW  = AW + 3
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             fsync,
   input  logic [NSTR-1:0]  ser_in,
   input  logic             drive_en,
   input  logic             cfg_we,
   input  logic [AW-1:0]    cfg_addr,
   input  logic [EW-1:0]    cfg_wdata,
   output logic [NSTR-1:0]  ser_out,
   output logic [NSTR-1:0]  ser_oe,
   output logic             ctl_out
);
   logic [PW-1:0]            cnt;
   logic                     fpar, wr_en, ctl_bit;
   logic [CW-1:0]            wr_chan;
   logic [NSTR-1:0][W-1:0]   wr_data, rd_data;
   logic [NSTR-1:0]          rd_bank, oe_q;
   logic [NSTR-1:0][AW-1:0]  rd_addr, rt_addr;
   logic [NSTR-1:0][EW-2:0]  rt_ent;

   tsi_rx #(.NSTR(NSTR), .NCH(NCH), .W(W)) rx_i (
      .clk(clk), .rst(rst), .fsync(fsync), .ser_in(ser_in),
      .cnt(cnt), .fpar(fpar), .wr_en(wr_en), .wr_chan(wr_chan), .wr_data(wr_data));

   tsi_dmem #(.NSTR(NSTR), .NCH(NCH), .W(W)) dmem_i (
      .clk(clk), .wr_en(wr_en), .wr_bank(fpar), .wr_chan(wr_chan), .wr_data(wr_data),
      .rd_bank(rd_bank), .rd_addr(rd_addr), .rd_data(rd_data));

   tsi_cmem #(.NSTR(NSTR), .NCH(NCH), .EW(EW)) cmem_i (
      .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata),
      .rt_addr(rt_addr), .rt_ent(rt_ent),
      .ctl_addr(AW'(cnt[PW-1:1])), .ctl_bit(ctl_bit));

   for (genvar s = 0; s < NSTR; s++) begin : g_tx
      assign rt_addr[s] = {SW'(s), cnt[PW-1:BW+1]};
      tsi_tx #(.NSTR(NSTR), .NCH(NCH), .W(W)) tx_i (
         .clk(clk), .rst(rst), .cnt(cnt), .fpar(fpar), .ent(rt_ent[s]),
         .rd_data(rd_data[s]), .rd_bank(rd_bank[s]), .rd_addr(rd_addr[s]),
         .ser_bit(ser_out[s]), .oe_q(oe_q[s]));
   end

   assign ser_oe = oe_q & {NSTR{drive_en}};

   always_ff @(posedge clk) begin
      if (rst)
         ctl_out <= 1'b0;
      else if (!cnt[0])
         ctl_out <= ctl_bit;
   end

   AST_CTL_HOLD: assert property (@(posedge clk) disable iff (rst)
      cnt[0] |=> $stable(ctl_out)); // R8
   AST_DRIVE_OFF: assert property (@(posedge clk) disable iff (rst)
      !drive_en |-> ser_oe == '0); // R7
endmodule

// File: tb/tsi_switch_tb_top.sv
module tsi_switch_tb_top;
   logic        clk = 1'b0;
   logic        rst = 1'b1;
   logic        fsync = 1'b0;
   logic [7:0]  ser_in = '0;
   logic        drive_en = 1'b1;
   logic        cfg_we = 1'b0;
   logic [7:0]  cfg_addr = '0;
   logic [10:0] cfg_wdata = '0;
   logic [7:0]  ser_out, ser_oe;
   logic        ctl_out;

   int vectors = 0;
   int miscompares = 0;
   bit done = 0;

   logic [7:0] cur [8][32];
   logic [7:0] prv [8][32];
   logic [2:0] m_st [256];
   logic [4:0] m_ch [256];
   logic       m_oe [256];
   logic       m_cd [256];
   logic       m_cb [256];

   always #4 clk = ~clk;

   tsi_switch dut_i (
      .clk(clk), .rst(rst), .fsync(fsync), .ser_in(ser_in), .drive_en(drive_en),
      .cfg_we(cfg_we), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata),
      .ser_out(ser_out), .ser_oe(ser_oe), .ctl_out(ctl_out));

   task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
      vectors++;
      if (act !== exp) begin
         miscompares++;
         $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
      end
   endtask

   // R9: entry layout {ctl, const, oe, stream[2:0], chan[4:0]}
   task automatic program_map();
      for (int a = 0; a < 256; a++) begin
         @(negedge clk);
         cfg_we    = 1'b1;
         cfg_addr  = 8'(a);
         cfg_wdata = {m_cb[a], m_cd[a], m_oe[a], m_st[a], m_ch[a]};
      end
      @(negedge clk);
      cfg_we = 1'b0;
   endtask

   task automatic check_pos(input int p, input bit dchk);
      int j, k, b, a;
      logic [7:0] src;
      logic exp_oe;
      j = (p - 1) / 2;
      k = j / 8;
      b = j % 8;
      for (int s = 0; s < 8; s++) begin
         a = s * 32 + k;
         exp_oe = drive_en & m_oe[a];
         chk($sformatf("%s slot s%0d c%0d", drive_en ? "R6" : "R7", s, k),
             8'(ser_oe[s]), 8'(exp_oe));
         if (exp_oe && dchk) begin
            if (!m_cd[a] && m_ch[a] < 5'(k)) src = cur[m_st[a]][m_ch[a]];
            else                             src = prv[m_st[a]][m_ch[a]];
            chk($sformatf("%s R2 R3 R9 slot s%0d c%0d bit%0d",
                          m_cd[a] ? "R5" : "R4", s, k, b),
                8'(ser_out[s]), 8'(src[7-b]));
         end
      end
      chk($sformatf("R8 control bit %0d", j), 8'(ctl_out), 8'(m_cb[j]));
   endtask

   task automatic run_frames(input int n);
      @(negedge clk);
      fsync = 1'b1;
      for (int f = 0; f < n; f++) begin
         for (int s = 0; s < 8; s++)
            for (int c = 0; c < 32; c++) begin
               prv[s][c] = cur[s][c];
               cur[s][c] = 8'($urandom);
            end
         for (int p = 0; p < 512; p++) begin
            @(negedge clk);
            for (int s = 0; s < 8; s++) ser_in[s] = cur[s][p/16][7 - (p/2) % 8];
            fsync = (p == 511);
            if (p % 2 == 1) check_pos(p, f > 0);
         end
      end
      fsync = 1'b0;
   endtask

   task automatic t_reset();
      repeat (4) @(negedge clk);
      rst = 1'b0;
      @(negedge clk);
      chk("R1 ser_oe", ser_oe, 8'h00);
      chk("R1 ser_out", ser_out, 8'h00);
      chk("R1 ctl_out", 8'(ctl_out), 8'h00);
   endtask

   task automatic t_identity();
      for (int a = 0; a < 256; a++) begin
         m_st[a] = 3'(a / 32); m_ch[a] = 5'(a % 32);
         m_oe[a] = 1'b1; m_cd[a] = 1'b0; m_cb[a] = 1'($urandom);
      end
      program_map();
      run_frames(3);
   endtask

   task automatic t_random_min();
      for (int r = 0; r < 2; r++) begin
         for (int a = 0; a < 256; a++) begin
            m_st[a] = 3'($urandom); m_ch[a] = 5'($urandom);
            m_oe[a] = 1'b1; m_cd[a] = 1'b0; m_cb[a] = 1'($urandom);
         end
         program_map();
         run_frames(3);
      end
   endtask

   task automatic t_constant();
      for (int a = 0; a < 256; a++) begin
         m_st[a] = 3'($urandom); m_ch[a] = 5'($urandom);
         m_oe[a] = 1'b1; m_cd[a] = 1'b1; m_cb[a] = 1'($urandom);
      end
      // R5 group: stream 0 carries stream 1 rotated, crossing the frame edge
      for (int k = 0; k < 32; k++) begin
         m_st[k] = 3'd1; m_ch[k] = 5'((k + 20) % 32);
      end
      program_map();
      run_frames(3);
   endtask

   task automatic t_mixed(input logic de);
      for (int a = 0; a < 256; a++) begin
         m_st[a] = 3'($urandom); m_ch[a] = 5'($urandom);
         m_oe[a] = 1'($urandom); m_cd[a] = 1'($urandom); m_cb[a] = 1'($urandom);
      end
      program_map();
      drive_en = de;
      run_frames(2);
      drive_en = 1'b1;
   endtask

   initial begin
      for (int s = 0; s < 8; s++)
         for (int c = 0; c < 32; c++) cur[s][c] = '0;
      for (int a = 0; a < 256; a++) begin
         m_st[a] = '0; m_ch[a] = '0; m_oe[a] = 1'b0; m_cd[a] = 1'b0; m_cb[a] = 1'b0;
      end
      t_reset();
      t_identity();
      t_random_min();
      t_constant();
      t_mixed(1'b1);
      t_mixed(1'b0);
      if (!done) begin
         done = 1;
         $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
         $finish;
      end
   end

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         done = 1;
         vectors++;
         miscompares++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
         $finish;
      end
   end
endmodule